// File: doc/BRIEF.md
# Paged Fetch-Address Unit with Return Stack

This block produces the program fetch address for a small accumulator CPU whose program memory holds 14-bit instruction words, one word per address. Each clock is one instruction cycle. The decoder drives one strobe per cycle, describing the instruction at the current fetch address. With no strobe the address advances by one. Absolute jumps and calls carry an 11-bit in-page target. The two address bits above that target come from a separately loaded page-latch register, not from the current address. A write to the low byte of the program counter makes a computed jump inside a 256-word window, and all five bits above the low byte come from the same latch.

Return addresses live in a hardware stack that software cannot reach. The stack is eight entries deep and circular. A call pushes the address after the call. A return pops it. A return-with-literal also hands an 8-bit immediate to the accumulator, so a computed jump into a run of such instructions gives a lookup table. A flush output marks the instruction cycle after every taken transfer, so that the prefetched word can be discarded.

Top module: `pcu_fetch_addr`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `fetch_addr` = 0, `flush` = 0, `w_load` = 0, the stack pointer at entry 0 and every stack entry at 0.
- R2: In a cycle with no strobe, `fetch_addr` becomes `fetch_addr + 1` modulo 2^13, so 0x1FFF is followed by 0x0000.
- R3: A jump or a call makes the next `fetch_addr` equal {`page_latch[4:3]`, `jmp_target[10:0]`}. The upper bits of the current address and `page_latch[2:0]` have no effect.
- R4: A low-byte write makes the next `fetch_addr` equal {`page_latch[4:0]`, `pcl_wdata[7:0]`}.
- R5: A call pushes `fetch_addr + 1`. A return loads `fetch_addr` from the most recent push that has not yet been popped, in last-in first-out order.
- R6: A return-with-literal pops the stack like a return. In the next cycle it also gives `w_load` = 1 and `w_data` = the `ret_literal` value from the instruction. `w_load` is 0 after every other kind of cycle.
- R7: The stack has 8 entries and wraps around. A ninth push without a pop overwrites the oldest entry. A pop from an empty stack wraps and returns that slot, which reads 0 after reset.
- R8: `flush` is 1 in the cycle after any taken transfer (jump, call, return, return-with-literal, low-byte write). It is 0 after a sequential cycle.
- R9: When several strobes are high together, the priority is: return or return-with-literal first, then call, then jump, then low-byte write. Only the winner acts, so a call that loses pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| call_stb | input | 1 | Current instruction is a call |
| goto_stb | input | 1 | Current instruction is an absolute jump |
| ret_stb | input | 1 | Current instruction is a return |
| retlw_stb | input | 1 | Current instruction is a return with literal |
| pcl_wr_stb | input | 1 | Current instruction writes the PC low byte |
| jmp_target | input | 11 | In-page target of a jump or call |
| page_latch | input | 5 | Page-latch register value |
| pcl_wdata | input | 8 | Data written to the PC low byte |
| ret_literal | input | 8 | Immediate carried by a return-with-literal |
| fetch_addr | output | 13 | Program fetch address |
| flush | output | 1 | The cycle after a taken transfer; prefetched word is void |
| w_load | output | 1 | Load `w_data` into the accumulator |
| w_data | output | 8 | Literal for the accumulator |

## Verification
The bench builds the block with its default parameters: a 13-bit address, an 11-bit in-page target, an 8-bit low byte and an 8-entry stack. With a stack that shallow, nine nested calls followed by nine returns are enough to show the oldest entry being overwritten and the pointer wrapping. The 13-bit width lets a single jump to 0x1FFF show the increment wrapping to zero. A return issued just after reset shows that an underflow wraps to a cleared slot.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int unsigned PC_W_DEF      = 13;
    localparam int unsigned TGT_W_DEF     = 11;
    localparam int unsigned LOW_W_DEF     = 8;
    localparam int unsigned STK_DEPTH_DEF = 8;

    typedef enum logic [1:0] {
        NXT_SEQ,
        NXT_PAGE_JMP,
        NXT_LOW_JMP,
        NXT_POP
    } nxt_src_e;

    typedef struct packed {
        logic call;
        logic go;
        logic ret;
        logic retlw;
        logic pcl_wr;
    } strobes_t;

    // Fixed priority: any return, then call, then jump, then low-byte write.
    function automatic nxt_src_e pick_src(strobes_t s);
        if (s.ret || s.retlw)     return NXT_POP;
        else if (s.call || s.go)  return NXT_PAGE_JMP;
        else if (s.pcl_wr)        return NXT_LOW_JMP;
        else                      return NXT_SEQ;
    endfunction

endpackage

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
    import pcu_pkg::*;
#(
    parameter int unsigned PC_W  = PC_W_DEF,
    parameter int unsigned TGT_W = TGT_W_DEF,
    parameter int unsigned LOW_W = LOW_W_DEF,
    localparam int unsigned HI_J  = PC_W - TGT_W,
    localparam int unsigned LAT_W = PC_W - LOW_W
) (
    input  strobes_t           stb,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [TGT_W-1:0]   jmp_target,
    input  logic [LAT_W-1:0]   page_latch,
    input  logic [LOW_W-1:0]   pcl_wdata,
    input  logic [PC_W-1:0]    pop_addr,
    output logic [PC_W-1:0]    nxt_pc,
    output logic [PC_W-1:0]    ret_addr,
    output logic               push,
    output logic               pop,
    output logic               taken,
    output logic               lit_ret
);

    nxt_src_e src;

    always_comb begin
        src      = pick_src(stb);
        ret_addr = cur_pc + PC_W'(1);
        push     = (src == NXT_PAGE_JMP) && stb.call;
        pop      = (src == NXT_POP);
        lit_ret  = (src == NXT_POP) && stb.retlw;
        taken    = (src != NXT_SEQ);
        unique case (src)
            NXT_PAGE_JMP: nxt_pc = {page_latch[LAT_W-1 -: HI_J], jmp_target};
            NXT_LOW_JMP:  nxt_pc = {page_latch, pcl_wdata};
            NXT_POP:      nxt_pc = pop_addr;
            default:      nxt_pc = ret_addr;
        endcase
    end

endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int unsigned AW    = 13,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr
);

    logic [PTR_W-1:0] sp_q;
    logic [AW-1:0]    ent_q [DEPTH];
    logic [DEPTH-1:0] wr_en;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_wen
            assign wr_en[gi] = push && (sp_q == PTR_W'(gi));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if (wr_en[i]) ent_q[i] <= push_addr;
            if (push)     sp_q <= sp_q + PTR_W'(1);
            else if (pop) sp_q <= sp_q - PTR_W'(1);
        end
    end

    assign top_addr = ent_q[sp_q - PTR_W'(1)];

    // R5
    push_then_top_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> (top_addr == $past(push_addr)));

    // R5
    no_push_pop_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

endmodule

// File: rtl/pcu_fetch_addr.sv
module pcu_fetch_addr
    import pcu_pkg::*;
#(
    parameter int unsigned PC_W      = PC_W_DEF,
    parameter int unsigned TGT_W     = TGT_W_DEF,
    parameter int unsigned LOW_W     = LOW_W_DEF,
    parameter int unsigned STK_DEPTH = STK_DEPTH_DEF,
    localparam int unsigned LAT_W    = PC_W - LOW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_stb,
    input  logic              goto_stb,
    input  logic              ret_stb,
    input  logic              retlw_stb,
    input  logic              pcl_wr_stb,
    input  logic [TGT_W-1:0]  jmp_target,
    input  logic [LAT_W-1:0]  page_latch,
    input  logic [LOW_W-1:0]  pcl_wdata,
    input  logic [LOW_W-1:0]  ret_literal,
    output logic [PC_W-1:0]   fetch_addr,
    output logic              flush,
    output logic              w_load,
    output logic [LOW_W-1:0]  w_data
);

    strobes_t          stb;
    logic [PC_W-1:0]   pc_q, nxt_pc, ret_addr, top_addr;
    logic              push, pop, taken, lit_ret;
    logic              flush_q, wl_q;
    logic [LOW_W-1:0]  wd_q;

    assign stb = '{call: call_stb, go: goto_stb, ret: ret_stb,
                   retlw: retlw_stb, pcl_wr: pcl_wr_stb};

    pcu_next_sel #(.PC_W(PC_W), .TGT_W(TGT_W), .LOW_W(LOW_W)) u_sel (
        .stb        (stb),
        .cur_pc     (pc_q),
        .jmp_target (jmp_target),
        .page_latch (page_latch),
        .pcl_wdata  (pcl_wdata),
        .pop_addr   (top_addr),
        .nxt_pc     (nxt_pc),
        .ret_addr   (ret_addr),
        .push       (push),
        .pop        (pop),
        .taken      (taken),
        .lit_ret    (lit_ret)
    );

    pcu_ret_stack #(.AW(PC_W), .DEPTH(STK_DEPTH)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_addr (ret_addr),
        .top_addr  (top_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            flush_q <= 1'b0;
            wl_q    <= 1'b0;
            wd_q    <= '0;
        end else begin
            pc_q    <= nxt_pc;
            flush_q <= taken;
            wl_q    <= lit_ret;
            if (lit_ret) wd_q <= ret_literal;
        end
    end

    assign fetch_addr = pc_q;
    assign flush      = flush_q;
    assign w_load     = wl_q;
    assign w_data     = wd_q;

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(call_stb || goto_stb || ret_stb || retlw_stb || pcl_wr_stb)
        |=> (fetch_addr == $past(fetch_addr) + PC_W'(1)));

    // R3
    page_jump_chk: assert property (@(posedge clk) disable iff (rst)
        ((call_stb || goto_stb) && !ret_stb && !retlw_stb)
        |=> (fetch_addr == {$past(page_latch[LAT_W-1 -: PC_W-TGT_W]), $past(jmp_target)}));

    // R4
    low_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (pcl_wr_stb && !call_stb && !goto_stb && !ret_stb && !retlw_stb)
        |=> (fetch_addr == {$past(page_latch), $past(pcl_wdata)}));

    // R8
    flush_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (call_stb || goto_stb || ret_stb || retlw_stb || pcl_wr_stb) |=> flush);

    // R6
    wload_chk: assert property (@(posedge clk) disable iff (rst)
        retlw_stb |=> (w_load && w_data == $past(ret_literal)));

    // R6
    wload_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !retlw_stb |=> !w_load);

endmodule

// File: tb/pcu_fetch_addr_tb.sv
module pcu_fetch_addr_tb_top;

    typedef struct {
        logic [12:0] addr;
        logic        flush;
        logic        wl;
        logic [7:0]  wd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_stb = 0, goto_stb = 0, ret_stb = 0, retlw_stb = 0, pcl_wr_stb = 0;
    logic [10:0] jmp_target = '0;
    logic [4:0]  page_latch = '0;
    logic [7:0]  pcl_wdata = '0, ret_literal = '0;
    logic [12:0] fetch_addr;
    logic        flush, w_load;
    logic [7:0]  w_data;

    int   n_chk = 0, n_fail = 0;
    bit   done = 0;
    exp_t q[$];

    logic [12:0] m_pc = '0;
    logic [12:0] m_stk [8];
    int          m_sp = 0;

    always #2 clk = ~clk;

    pcu_fetch_addr dut_i (
        .clk(clk), .rst(rst),
        .call_stb(call_stb), .goto_stb(goto_stb), .ret_stb(ret_stb),
        .retlw_stb(retlw_stb), .pcl_wr_stb(pcl_wr_stb),
        .jmp_target(jmp_target), .page_latch(page_latch),
        .pcl_wdata(pcl_wdata), .ret_literal(ret_literal),
        .fetch_addr(fetch_addr), .flush(flush),
        .w_load(w_load), .w_data(w_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // s = {call, goto, ret, retlw, pcl_wr}
    task automatic drive(input logic [4:0] s, input logic [10:0] tgt,
                         input logic [4:0] lat, input logic [7:0] pd,
                         input logic [7:0] lit, input string tag);
        exp_t e;
        {call_stb, goto_stb, ret_stb, retlw_stb, pcl_wr_stb} = s;
        jmp_target = tgt; page_latch = lat; pcl_wdata = pd; ret_literal = lit;
        e.flush = (s != 0);
        e.wl = 1'b0;
        e.wd = lit;
        e.tag = tag;
        if (s[2] || s[1]) begin
            m_sp = (m_sp + 7) % 8;
            m_pc = m_stk[m_sp];
            e.wl = s[1];
        end else if (s[4] || s[3]) begin
            if (s[4]) begin
                m_stk[m_sp] = m_pc + 13'd1;
                m_sp = (m_sp + 1) % 8;
            end
            m_pc = {lat[4:3], tgt};
        end else if (s[0]) begin
            m_pc = {lat, pd};
        end else begin
            m_pc = m_pc + 13'd1;
        end
        e.addr = m_pc;
        q.push_back(e);
        @(negedge clk); #1;
    endtask

    // Scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(fetch_addr == e.addr, e.tag, "fetch_addr", fetch_addr, e.addr);
            check(flush == e.flush, e.tag, "flush", flush, e.flush);
            check(w_load == e.wl, e.tag, "w_load", w_load, e.wl);
            if (e.wl) check(w_data == e.wd, e.tag, "w_data", w_data, e.wd);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1: reset state
        check(fetch_addr == 0, "R1", "fetch_addr", fetch_addr, 0);
        check(flush == 0, "R1", "flush", flush, 0);
        check(w_load == 0, "R1", "w_load", w_load, 0);
        rst = 1'b0;

        // R7 underflow right after reset wraps to a cleared slot (R1 stack clear)
        drive(5'b00100, 0, 0, 0, 0, "R7_underflow");
        drive(5'b00000, 0, 0, 0, 0, "R2");
        drive(5'b00000, 0, 0, 0, 0, "R2");
        // R3: upper latch bits only; low latch bits ignored
        drive(5'b01000, 11'h7FF, 5'b11010, 8'h99, 0, "R3_goto");
        // R2: wrap 0x1FFF -> 0
        drive(5'b00000, 0, 0, 0, 0, "R2_wrap");
        // R4: computed jump
        drive(5'b00001, 11'h2AA, 5'h15, 8'h3C, 0, "R4_pcl");
        // R5: nested calls
        drive(5'b10000, 11'h123, 5'h08, 0, 0, "R5_call");
        drive(5'b10000, 11'h456, 5'h07, 0, 0, "R5_call");
        drive(5'b00000, 0, 0, 0, 0, "R8_seq");
        // R6: return with literal
        drive(5'b00010, 0, 0, 0, 8'hA5, "R6_retlw");
        drive(5'b00100, 0, 0, 0, 8'h11, "R5_ret");
        // R9: priority
        drive(5'b01001, 11'h0F0, 5'h10, 8'h77, 0, "R9_goto_over_pcl");
        drive(5'b10001, 11'h00E, 5'h18, 8'h55, 0, "R9_call_over_pcl");
        drive(5'b10100, 11'h3FF, 5'h1F, 0, 0, "R9_ret_over_call");
        // R7: overflow by nine calls, then nine returns
        for (int i = 0; i < 9; i++)
            drive(5'b10000, 11'(16 * i + 3), 5'(i), 0, 0, "R7_push");
        for (int i = 0; i < 9; i++)
            drive(5'b00100, 0, 0, 0, 0, "R7_pop");
        drive(5'b00000, 0, 0, 0, 0, "R8_seq");
        drive(5'b00010, 0, 0, 0, 8'h3E, "R6_retlw");
        drive(5'b00000, 0, 0, 0, 8'hFF, "R6_quiet");
        @(negedge clk); #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule